// File: doc/BRIEF.md
# Sleep Plane Sequencer

This block turns a requested system sleep level into three active-low plane controls and into isolation settings for the interface pins that lead into domains which may lose power. A shallow standby level only slows the clock generator. The suspend level also removes processor and main power but leaves memory powered so that its contents are kept. The two deepest levels (hibernate and off) also release the memory plane. The controls are nested: a deeper level always keeps every shallower control asserted.

When the system wakes, the controls are released one clock apart, deepest first. Pin isolation is lifted only after main power has been declared back on. Isolation depends on the interface. Disk-channel outputs either float or are held low, and their input buffers are gated. Each USB port is isolated only when no wake path through that port is requested. Audio-link outputs are held low and their inputs are gated. A set of device-plane enables written by software passes to the device-plane outputs without regard to the sleep level.

Top module: `sleep_plane_ctrl`

## Requirements
- R1: While reset is low, and after it, the outputs are: all three sleep controls high, device-plane outputs 0, every interface output and input enable 1, and every force-low 0.
- R2: The request is coded on `reqState` as 0 = awake, 1 = standby, 3 = suspend, 4 = hibernate, 5 = off. In standby only `clkSlowN` is low.
- R3: In suspend, `clkSlowN` and `mainOffN` are low and `memOffN` is high. A low `memOffN` never occurs without a low `mainOffN`, and a low `mainOffN` never occurs without a low `clkSlowN`.
- R4: In hibernate and in off, all three sleep controls are low.
- R5: A request for a deeper level asserts every control it needs at the same time. The change appears at the ports on the second rising edge after the request is presented.
- R6: A request for a shallower level releases the controls one per clock, deepest first: `memOffN`, then `mainOffN`, then `clkSlowN`.
- R7: Isolation begins on the same edge at which `mainOffN` goes low. It ends one clock after `mainOffN` returns high.
- R8: While isolated, the disk channel gates its input buffers (`ideInEn`=0). With `ideLowMode`=1 it keeps its output enabled and forced low (`ideOutEn`=1, `ideForceLow`=1). With `ideLowMode`=0 it floats its outputs (`ideOutEn`=0, `ideForceLow`=0).
- R9: While isolated, USB port i disables its output enable and its input enable only when `usbWakeEn[i]`=0. A port with wake enabled stays fully enabled.
- R10: While isolated, every audio lane has `audForceLow`=1 and `audInEn`=0.
- R11: `devPlaneOut` equals `devPlaneEn` as sampled on the previous rising edge, at every sleep level.
- R12: The unused request codes 2, 6 and 7 are ignored. Sleep controls and isolation stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqState | input | 3 | Requested sleep level code |
| devPlaneEn | input | NUM_DEV | Software device-plane enables |
| usbWakeEn | input | USB_PORTS | Per-port USB wake enable |
| ideLowMode | input | 1 | Disk isolation: 1 = drive low, 0 = float |
| clkSlowN | output | 1 | Active-low clock-generator slow control |
| mainOffN | output | 1 | Active-low processor/main plane off |
| memOffN | output | 1 | Active-low memory plane off |
| devPlaneOut | output | NUM_DEV | Device-plane power controls |
| ideOutEn | output | IDE_LANES | Disk output enables |
| ideForceLow | output | IDE_LANES | Disk output force-low |
| ideInEn | output | IDE_LANES | Disk input buffer enables |
| usbOutEn | output | USB_PORTS | USB output enables |
| usbInEn | output | USB_PORTS | USB input buffer enables |
| audForceLow | output | AUD_LANES | Audio output force-low |
| audInEn | output | AUD_LANES | Audio input buffer enables |

## Verification
The block holds only three level bits and one isolation bit. A wrong value in any of them shows at the ports on the next rising edge, as a sleep control or an interface enable out of step with the request. A wrong release order shows as two controls rising on the same edge. An isolation bit that clears too early shows as an interface enable returning while `mainOffN` is still low or has only just risen. The bench compares every port on every cycle, so any such divergence is caught within one clock of its appearance.

// File: rtl/sleepPlanePkg.sv
package sleepPlanePkg;
  localparam int REQ_W = 3;
  localparam logic [REQ_W-1:0] REQ_AWAKE   = 3'd0;
  localparam logic [REQ_W-1:0] REQ_STANDBY = 3'd1;
  localparam logic [REQ_W-1:0] REQ_SUSPEND = 3'd3;
  localparam logic [REQ_W-1:0] REQ_HIBER   = 3'd4;
  localparam logic [REQ_W-1:0] REQ_OFF     = 3'd5;
  localparam int LVL_W = 3;   // bit0 clock slow, bit1 main off, bit2 memory off

  typedef struct packed {
    logic clkSlow;
    logic mainOff;
    logic memOff;
    logic isolate;
  } planeStrobes_t;
endpackage

// File: rtl/sleep_req_decode.sv
module sleep_req_decode
  import sleepPlanePkg::*;
(
  input  logic [REQ_W-1:0] reqCode,
  output logic             reqValid,
  output logic [LVL_W-1:0] tgtLevels
);
  always_comb begin
    reqValid  = 1'b1;
    tgtLevels = '0;
    case (reqCode)
      REQ_AWAKE:   tgtLevels = 3'b000;
      REQ_STANDBY: tgtLevels = 3'b001;
      REQ_SUSPEND: tgtLevels = 3'b011;
      REQ_HIBER:   tgtLevels = 3'b111;
      REQ_OFF:     tgtLevels = 3'b111;
      default: begin
        reqValid  = 1'b0;
        tgtLevels = '0;
      end
    endcase
  end
endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleepPlanePkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic [LVL_W-1:0] tgtLevels,
  output planeStrobes_t    strobes
);
  logic [LVL_W-1:0] lvl, lvlNext;
  logic             iso, isoNext;
  logic             deeper;

  always_comb begin
    lvlNext = lvl;
    isoNext = iso;
    deeper  = |(tgtLevels & ~lvl);
    if (reqValid) begin
      if (deeper) begin
        lvlNext = tgtLevels;
        if (tgtLevels[1]) isoNext = 1'b1;
      end else if (lvl[2] && !tgtLevels[2]) begin
        lvlNext[2] = 1'b0;
      end else if (lvl[1] && !tgtLevels[1]) begin
        lvlNext[1] = 1'b0;
      end else if (lvl[0] && !tgtLevels[0]) begin
        lvlNext[0] = 1'b0;
      end
      // release isolation only once main power was already back on
      if (iso && !lvl[1] && !tgtLevels[1]) isoNext = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lvl <= '0;
      iso <= 1'b0;
    end else begin
      lvl <= lvlNext;
      iso <= isoNext;
    end
  end

  assign strobes.clkSlow = lvl[0];
  assign strobes.mainOff = lvl[1];
  assign strobes.memOff  = lvl[2];
  assign strobes.isolate = iso;

  // R3 nesting of levels
  a_r3_nested: assert property (@(posedge clk) disable iff (!rstN)
    (lvl[2] |-> lvl[1]) and (lvl[1] |-> lvl[0]));
  // R6 release order: one level per clock, deepest first
  a_r6_main_after_mem: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lvl[1]) |-> $past(!lvl[2]));
  a_r6_clk_after_main: assert property (@(posedge clk) disable iff (!rstN)
    $fell(lvl[0]) |-> $past(!lvl[1]));
  // R7 isolation covers every cycle with main power off, released late
  a_r7_iso_cover: assert property (@(posedge clk) disable iff (!rstN)
    lvl[1] |-> iso);
  a_r7_iso_release: assert property (@(posedge clk) disable iff (!rstN)
    $fell(iso) |-> $past(!lvl[1]));
  // R12 unused codes hold state
  a_r12_ignore: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> ($stable(lvl) && $stable(iso)));
endmodule

// File: rtl/sleep_plane_datapath.sv
module sleep_plane_datapath
  import sleepPlanePkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int IDE_LANES = 2,
  parameter int USB_PORTS = 4,
  parameter int AUD_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  planeStrobes_t        strobes,
  input  logic [NUM_DEV-1:0]   devPlaneEn,
  input  logic [USB_PORTS-1:0] usbWakeEn,
  input  logic                 ideLowMode,
  output logic                 clkSlowN,
  output logic                 mainOffN,
  output logic                 memOffN,
  output logic [NUM_DEV-1:0]   devPlaneOut,
  output logic [IDE_LANES-1:0] ideOutEn,
  output logic [IDE_LANES-1:0] ideForceLow,
  output logic [IDE_LANES-1:0] ideInEn,
  output logic [USB_PORTS-1:0] usbOutEn,
  output logic [USB_PORTS-1:0] usbInEn,
  output logic [AUD_LANES-1:0] audForceLow,
  output logic [AUD_LANES-1:0] audInEn
);
  always_ff @(posedge clk) begin
    if (!rstN) begin
      clkSlowN    <= 1'b1;
      mainOffN    <= 1'b1;
      memOffN     <= 1'b1;
      devPlaneOut <= '0;
    end else begin
      clkSlowN    <= !strobes.clkSlow;
      mainOffN    <= !strobes.mainOff;
      memOffN     <= !strobes.memOff;
      devPlaneOut <= devPlaneEn;
    end
  end

  for (genvar i = 0; i < IDE_LANES; i++) begin : g_ide
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ideOutEn[i]    <= 1'b1;
        ideForceLow[i] <= 1'b0;
        ideInEn[i]     <= 1'b1;
      end else begin
        ideOutEn[i]    <= !strobes.isolate || ideLowMode;
        ideForceLow[i] <= strobes.isolate && ideLowMode;
        ideInEn[i]     <= !strobes.isolate;
      end
    end
    // R8 a forced-low lane is always driven
    a_r8_low_driven: assert property (@(posedge clk) disable iff (!rstN)
      ideForceLow[i] |-> (ideOutEn[i] && !ideInEn[i]));
  end

  for (genvar i = 0; i < USB_PORTS; i++) begin : g_usb
    logic portOff;
    assign portOff = strobes.isolate && !usbWakeEn[i];
    always_ff @(posedge clk) begin
      if (!rstN) begin
        usbOutEn[i] <= 1'b1;
        usbInEn[i]  <= 1'b1;
      end else begin
        usbOutEn[i] <= !portOff;
        usbInEn[i]  <= !portOff;
      end
    end
    // R9 a wake-enabled port keeps its input alive
    a_r9_wake_alive: assert property (@(posedge clk) disable iff (!rstN)
      usbWakeEn[i] |=> (usbInEn[i] && usbOutEn[i]));
  end

  for (genvar i = 0; i < AUD_LANES; i++) begin : g_aud
    always_ff @(posedge clk) begin
      if (!rstN) begin
        audForceLow[i] <= 1'b0;
        audInEn[i]     <= 1'b1;
      end else begin
        audForceLow[i] <= strobes.isolate;
        audInEn[i]     <= !strobes.isolate;
      end
    end
    // R10 audio lanes isolate whenever main power is off
    a_r10_aud_iso: assert property (@(posedge clk) disable iff (!rstN)
      !mainOffN |-> (audForceLow[i] && !audInEn[i]));
  end

  // R11 device planes follow enables one clock later
  a_r11_dev_follow: assert property (@(posedge clk) disable iff (!rstN)
    rstN |=> devPlaneOut == $past(devPlaneEn));
  // R3 memory plane never off while main power on
  a_r3_port_nest: assert property (@(posedge clk) disable iff (!rstN)
    !memOffN |-> (!mainOffN && !clkSlowN));
endmodule

// File: rtl/sleep_plane_ctrl.sv
module sleep_plane_ctrl
  import sleepPlanePkg::*;
#(
  parameter int NUM_DEV   = 4,
  parameter int IDE_LANES = 2,
  parameter int USB_PORTS = 4,
  parameter int AUD_LANES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [2:0]           reqState,
  input  logic [NUM_DEV-1:0]   devPlaneEn,
  input  logic [USB_PORTS-1:0] usbWakeEn,
  input  logic                 ideLowMode,
  output logic                 clkSlowN,
  output logic                 mainOffN,
  output logic                 memOffN,
  output logic [NUM_DEV-1:0]   devPlaneOut,
  output logic [IDE_LANES-1:0] ideOutEn,
  output logic [IDE_LANES-1:0] ideForceLow,
  output logic [IDE_LANES-1:0] ideInEn,
  output logic [USB_PORTS-1:0] usbOutEn,
  output logic [USB_PORTS-1:0] usbInEn,
  output logic [AUD_LANES-1:0] audForceLow,
  output logic [AUD_LANES-1:0] audInEn
);
  logic             reqValid;
  logic [LVL_W-1:0] tgtLevels;
  planeStrobes_t    strobes;

  sleep_req_decode uDecode (
    .reqCode  (reqState),
    .reqValid (reqValid),
    .tgtLevels(tgtLevels)
  );

  sleep_seq_ctrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .reqValid (reqValid),
    .tgtLevels(tgtLevels),
    .strobes  (strobes)
  );

  sleep_plane_datapath #(
    .NUM_DEV  (NUM_DEV),
    .IDE_LANES(IDE_LANES),
    .USB_PORTS(USB_PORTS),
    .AUD_LANES(AUD_LANES)
  ) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .devPlaneEn (devPlaneEn),
    .usbWakeEn  (usbWakeEn),
    .ideLowMode (ideLowMode),
    .clkSlowN   (clkSlowN),
    .mainOffN   (mainOffN),
    .memOffN    (memOffN),
    .devPlaneOut(devPlaneOut),
    .ideOutEn   (ideOutEn),
    .ideForceLow(ideForceLow),
    .ideInEn    (ideInEn),
    .usbOutEn   (usbOutEn),
    .usbInEn    (usbInEn),
    .audForceLow(audForceLow),
    .audInEn    (audInEn)
  );
endmodule

// File: tb/tb_sleep_plane_ctrl.sv
module tb_sleep_plane_ctrl;
  localparam int ND = 4;
  localparam int NI = 2;
  localparam int NU = 4;
  localparam int NA = 2;
  localparam int VW = 3 + ND + 3*NI + 2*NU + 2*NA;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          rstN;
  logic [2:0]    reqState;
  logic [ND-1:0] devPlaneEn;
  logic [NU-1:0] usbWakeEn;
  logic          ideLowMode;
  logic          clkSlowN, mainOffN, memOffN;
  logic [ND-1:0] devPlaneOut;
  logic [NI-1:0] ideOutEn, ideForceLow, ideInEn;
  logic [NU-1:0] usbOutEn, usbInEn;
  logic [NA-1:0] audForceLow, audInEn;

  sleep_plane_ctrl #(.NUM_DEV(ND), .IDE_LANES(NI), .USB_PORTS(NU), .AUD_LANES(NA)) dut (
    .clk(clk), .rstN(rstN), .reqState(reqState), .devPlaneEn(devPlaneEn),
    .usbWakeEn(usbWakeEn), .ideLowMode(ideLowMode), .clkSlowN(clkSlowN),
    .mainOffN(mainOffN), .memOffN(memOffN), .devPlaneOut(devPlaneOut),
    .ideOutEn(ideOutEn), .ideForceLow(ideForceLow), .ideInEn(ideInEn),
    .usbOutEn(usbOutEn), .usbInEn(usbInEn), .audForceLow(audForceLow),
    .audInEn(audInEn)
  );

  typedef struct {
    int            cyc;
    logic [VW-1:0] val;
    string         tag;
  } item_t;

  item_t       sbq[$];
  int          cyc = 0;
  int          checks = 0;
  int          errors = 0;
  logic [2:0]  mLvl;   // model: bit0 slow, bit1 main off, bit2 mem off
  logic        mIso;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [VW-1:0] observed();
    return {clkSlowN, mainOffN, memOffN, devPlaneOut, ideOutEn, ideForceLow,
            ideInEn, usbOutEn, usbInEn, audForceLow, audInEn};
  endfunction

  function automatic logic [VW-1:0] expectVec(input logic [2:0] l, input logic iso,
      input logic [ND-1:0] dv, input logic [NU-1:0] wk, input logic lm);
    logic [NU-1:0] off;
    off = {NU{iso}} & ~wk;
    return {!l[0], !l[1], !l[2], dv,
            {NI{!iso || lm}}, {NI{iso && lm}}, {NI{!iso}},
            ~off, ~off, {NA{iso}}, {NA{!iso}}};
  endfunction

  // behaviour from R2-R7 and R12
  task automatic modelStep(input logic [2:0] rq);
    logic [2:0] t;
    logic       ok;
    logic [2:0] nl;
    logic       ni;
    ok = 1'b1;
    case (rq)
      3'd0: t = 3'b000;
      3'd1: t = 3'b001;
      3'd3: t = 3'b011;
      3'd4, 3'd5: t = 3'b111;
      default: begin t = 3'b000; ok = 1'b0; end
    endcase
    nl = mLvl; ni = mIso;
    if (ok) begin
      if ((t & ~mLvl) != 3'b000) begin
        nl = t;
        if (t[1]) ni = 1'b1;
      end else if (mLvl[2] && !t[2]) nl[2] = 1'b0;
      else if (mLvl[1] && !t[1]) nl[1] = 1'b0;
      else if (mLvl[0] && !t[0]) nl[0] = 1'b0;
      if (mIso && !mLvl[1] && !t[1]) ni = 1'b0;
    end
    mLvl = nl; mIso = ni;
  endtask

  // driver: one expected item per cycle into the scoreboard
  task automatic drive(input logic [2:0] rq, input logic [ND-1:0] dv,
      input logic [NU-1:0] wk, input logic lm, input int n, input string tag);
    item_t it;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      reqState = rq; devPlaneEn = dv; usbWakeEn = wk; ideLowMode = lm;
      it.cyc = cyc + 1;
      it.val = expectVec(mLvl, mIso, dv, wk, lm);
      it.tag = tag;
      sbq.push_back(it);
      modelStep(rq);
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rstN) begin
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        item_t it;
        logic [VW-1:0] act;
        it = sbq.pop_front();
        act = observed();
        checks++;
        if (it.cyc != cyc || act !== it.val) begin
          errors++;
          $display("FAIL %s cyc=%0d actual=%h expected=%h", it.tag, cyc, act, it.val);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mLvl = 3'b000; mIso = 1'b0;
    rstN = 1'b0; reqState = 3'd5; devPlaneEn = 4'hF; usbWakeEn = '0; ideLowMode = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset values while reset held, even with a deep request present
    checks++;
    if (observed() !== expectVec(3'b000, 1'b0, '0, '1, 1'b0)) begin
      errors++;
      $display("FAIL R1 reset actual=%h expected=%h", observed(), expectVec(3'b000, 1'b0, '0, '1, 1'b0));
    end
    reqState = 3'd0; devPlaneEn = '0;
    @(negedge clk); rstN = 1'b1;
    drive(3'd0, 4'h0, 4'h0, 1'b0, 2, "R1 post-reset");
    drive(3'd1, 4'h0, 4'h0, 1'b0, 4, "R2 standby");
    drive(3'd0, 4'h0, 4'h0, 1'b0, 4, "R6 standby exit");
    drive(3'd3, 4'h3, 4'b0101, 1'b0, 5, "R3 R5 R8 R9 suspend float");
    drive(3'd0, 4'h3, 4'b0101, 1'b0, 5, "R6 R7 suspend exit");
    drive(3'd5, 4'h0, 4'b0000, 1'b1, 5, "R4 R5 R8 R10 off low-mode");
    drive(3'd0, 4'h0, 4'b0000, 1'b1, 6, "R6 R7 off exit order");
    drive(3'd4, 4'h9, 4'b1000, 1'b0, 4, "R4 R9 hibernate");
    drive(3'd3, 4'h6, 4'b1000, 1'b0, 3, "R6 hibernate to suspend");
    drive(3'd2, 4'h6, 4'b0010, 1'b0, 3, "R12 code 2 ignored");
    drive(3'd6, 4'hA, 4'b0010, 1'b1, 3, "R12 code 6 ignored");
    drive(3'd7, 4'h5, 4'b0010, 1'b1, 3, "R12 code 7 ignored");
    drive(3'd1, 4'h5, 4'b0000, 1'b1, 4, "R6 R7 suspend to standby");
    drive(3'd5, 4'hF, 4'b1111, 1'b0, 3, "R5 R9 standby to off");
    drive(3'd0, 4'hF, 4'b1111, 1'b0, 1, "R6 partial exit");
    drive(3'd3, 4'hC, 4'b0000, 1'b1, 4, "R5 R7 re-entry mid exit");
    drive(3'd0, 4'h1, 4'b0000, 1'b1, 1, "R7 early exit");
    drive(3'd2, 4'h2, 4'b0000, 1'b1, 3, "R12 ignored during exit");
    for (int d = 0; d < 4; d++)
      drive(3'd5, 4'(d), 4'b0000, 1'b0, 2, "R11 device planes asleep");
    drive(3'd0, 4'h0, 4'b0000, 1'b0, 6, "R6 final exit");
    drive(3'd0, 4'h0, 4'b0000, 1'b0, 2, "R1 idle");
    while (sbq.size() > 0) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule